// File: doc/BRIEF.md
# Scan Snapshot Event Detector

This block sits behind the shift engine of a serial input expander. Each time the engine finishes a scan of the input chain, it pulses `scan_done` for one cycle and presents the freshly captured input vector. The detector compares that vector with the vector from the previous scan. It raises per-pin events for the transitions that each pin's two-bit sensitivity field selects. It latches them in per-bank status bytes, and it drives a single combined interrupt line.

Software programs the sensitivity fields and services the status bytes through a small register port that takes 8-bit and 16-bit accesses. The first scan after reset, and the first scan after the detector is re-enabled, only establish the comparison baseline. Pin numbering starts at the first input port: input pin `i` lives in bank `i/8` at bit `i%8`, and `scan_data[i]` carries its level.

Top module: `sgp_event_det`

## Requirements
- R1: Reset clears every sensitivity word and every status byte to zero and holds `irq` low.
- R2: Bank `b` has a 16-bit sensitivity word at address 0x10+2*b, where pin `p` owns bits [2p+1:2p]. A halfword access (`reg_size`=1) reads or writes the whole word. A byte access (`reg_size`=0) to the even address reaches bits [7:0], and a byte access to the odd address reaches bits [15:8], returned in `reg_rdata[7:0]`.
- R3: Field value 2'b01 sets the pin's status bit when the pin was 0 in the previous scan and is 1 in the new scan.
- R4: Field value 2'b10 sets the pin's status bit on a 1-to-0 change between consecutive scans.
- R5: Field value 2'b11 sets the status bit on a change in either direction. Field value 2'b00 never sets it.
- R6: Bank `b` has a status byte at address 0x20+b, where bit `p` belongs to pin `p`. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R7: The first scan after reset, or after `scan_en` rises, records the baseline and sets no status bit.
- R8: The detector compares levels only on cycles where `scan_done` is high. Changes on `scan_data` without the pulse have no effect.
- R9: When a pin's event and a write-one-to-clear of that same bit land in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when some status bit is set whose pin has a nonzero sensitivity field. Zeroing the field masks the pin from `irq` but keeps its status bit.
- R11: While `scan_en` is low, `scan_done` pulses raise no events and do not update the baseline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Detector enable; low discards the baseline |
| scan_done | input | 1 | One-cycle pulse: a scan has completed |
| scan_data | input | 64 | Input levels captured by the completed scan |
| reg_wr | input | 1 | Register write strobe |
| reg_size | input | 1 | 0 = byte access, 1 = halfword access |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 16 | Write data (byte accesses use bits [7:0]) |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Combined event interrupt |

## Verification
A `scan_done` pulse sampled at a rising edge updates the status bytes at that same edge, and `irq` follows with no further register. Results are therefore due one cycle after the pulse is driven. A register write takes effect at the edge that sees `reg_wr`, and reads are combinational. The bench drives every input on the falling edge and reads status, words and `irq` at a later falling edge, well after the update has settled. A combined case drives a scan pulse and a clear in the same cycle to check the R9 priority.

// File: rtl/sgp_evt_pkg.sv
package sgp_evt_pkg;

    localparam int CFG_BASE  = 'h10;
    localparam int STAT_BASE = 'h20;

    typedef enum logic [1:0] {
        SENSE_OFF  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_HALF = 1'b1
    } acc_e;

    typedef struct packed {
        logic up;
        logic down;
    } transition_t;

    function automatic transition_t classify(input logic prev, input logic cur);
        transition_t t;
        t.up   = ~prev & cur;
        t.down = prev & ~cur;
        return t;
    endfunction

    function automatic logic sense_match(input sense_e m, input transition_t t);
        logic r;
        unique case (m)
            SENSE_OFF:  r = 1'b0;
            SENSE_RISE: r = t.up;
            SENSE_FALL: r = t.down;
            default:    r = t.up | t.down;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sgp_evt_bank.sv
module sgp_evt_bank
    import sgp_evt_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              compare,
    input  logic [PINS-1:0]   level,
    input  logic [2*PINS-1:0] sense,
    input  logic [PINS-1:0]   clr,
    output logic [PINS-1:0]   status,
    output logic [PINS-1:0]   armed,
    output logic [PINS-1:0]   hit
);

    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] stat_q;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        sense_e      mode_p;
        transition_t tr_p;
        assign mode_p   = sense_e'(sense[2*p +: 2]);
        assign tr_p     = classify(prev_q[p], level[p]);
        assign hit[p]   = sample & compare & sense_match(mode_p, tr_p);
        assign armed[p] = |sense[2*p +: 2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            if (sample) prev_q <= level;
            stat_q <= (stat_q & ~clr) | hit;
        end
    end

    assign status = stat_q;

endmodule

// File: rtl/sgp_evt_regport.sv
module sgp_evt_regport
    import sgp_evt_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int PINS  = 8,
    parameter int AW    = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    size,
    input  logic [AW-1:0]           addr,
    input  logic [2*PINS-1:0]       wdata,
    output logic [2*PINS-1:0]       rdata,
    input  logic [NBANK*PINS-1:0]   stat_i,
    output logic [NBANK*2*PINS-1:0] cfg_o,
    output logic [NBANK*PINS-1:0]   clr_o
);

    localparam int CFGW = 2 * PINS;
    localparam int HALF = CFGW / 2;
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [AW-1:0] cfg_off;
    logic [AW-1:0] stat_off;
    logic          cfg_hit;
    logic          stat_hit;
    logic [BW-1:0] cfg_bank;
    logic [BW-1:0] stat_bank;
    logic          hi_lane;
    acc_e          acc;

    assign acc       = acc_e'(size);
    assign cfg_off   = addr - AW'(CFG_BASE);
    assign stat_off  = addr - AW'(STAT_BASE);
    assign cfg_hit   = (addr >= AW'(CFG_BASE)) && (addr < AW'(CFG_BASE + 2*NBANK));
    assign stat_hit  = (addr >= AW'(STAT_BASE)) && (addr < AW'(STAT_BASE + NBANK));
    assign cfg_bank  = cfg_off[BW:1];
    assign stat_bank = stat_off[BW-1:0];
    assign hi_lane   = addr[0];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CFGW-1:0] word_q;
        logic            sel_cfg;
        logic            sel_stat;

        assign sel_cfg  = wr_en && cfg_hit && (cfg_bank == BW'(b));
        assign sel_stat = wr_en && stat_hit && (stat_bank == BW'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (sel_cfg) begin
                if (acc == ACC_HALF)  word_q <= wdata;
                else if (hi_lane)     word_q[CFGW-1:HALF] <= wdata[HALF-1:0];
                else                  word_q[HALF-1:0]    <= wdata[HALF-1:0];
            end
        end

        assign cfg_o[b*CFGW +: CFGW] = word_q;
        assign clr_o[b*PINS +: PINS] = sel_stat ? wdata[PINS-1:0] : '0;
    end

    always_comb begin
        logic [CFGW-1:0] word;
        word  = cfg_o[cfg_bank*CFGW +: CFGW];
        rdata = '0;
        if (cfg_hit) begin
            if (acc == ACC_HALF) rdata = word;
            else if (hi_lane)    rdata = CFGW'(word[CFGW-1:HALF]);
            else                 rdata = CFGW'(word[HALF-1:0]);
        end else if (stat_hit) begin
            rdata = CFGW'(stat_i[stat_bank*PINS +: PINS]);
        end
    end

endmodule

// File: rtl/sgp_event_det.sv
module sgp_event_det
    import sgp_evt_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int PINS  = 8,
    parameter int AW    = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scan_en,
    input  logic                  scan_done,
    input  logic [NBANK*PINS-1:0] scan_data,
    input  logic                  reg_wr,
    input  logic                  reg_size,
    input  logic [AW-1:0]         reg_addr,
    input  logic [2*PINS-1:0]     reg_wdata,
    output logic [2*PINS-1:0]     reg_rdata,
    output logic                  irq
);

    localparam int NPIN = NBANK * PINS;
    localparam int CFGW = 2 * PINS;

    logic              base_valid;
    logic              sample;
    logic [NBANK*CFGW-1:0] cfg_flat;
    logic [NPIN-1:0]   clr_flat;
    logic [NPIN-1:0]   stat_flat;
    logic [NPIN-1:0]   armed_flat;
    logic [NPIN-1:0]   hit_flat;

    assign sample = scan_done & scan_en;

    always_ff @(posedge clk) begin
        if (rst || !scan_en) base_valid <= 1'b0;
        else if (scan_done)  base_valid <= 1'b1;
    end

    sgp_evt_regport #(
        .NBANK (NBANK),
        .PINS  (PINS),
        .AW    (AW)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .size   (reg_size),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .stat_i (stat_flat),
        .cfg_o  (cfg_flat),
        .clr_o  (clr_flat)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sgp_evt_bank #(
            .PINS (PINS)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .sample  (sample),
            .compare (base_valid),
            .level   (scan_data[b*PINS +: PINS]),
            .sense   (cfg_flat[b*CFGW +: CFGW]),
            .clr     (clr_flat[b*PINS +: PINS]),
            .status  (stat_flat[b*PINS +: PINS]),
            .armed   (armed_flat[b*PINS +: PINS]),
            .hit     (hit_flat[b*PINS +: PINS])
        );
    end

    assign irq = |(stat_flat & armed_flat);

endmodule

// File: rtl/sgp_event_det_chk.sv
module sgp_event_det_chk
    import sgp_evt_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int PINS  = 8,
    parameter int AW    = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     scan_en,
    input logic                     scan_done,
    input logic                     base_valid,
    input logic                     reg_wr,
    input logic [AW-1:0]            reg_addr,
    input logic [NBANK*PINS-1:0]    stat_flat,
    input logic [NBANK*PINS-1:0]    hit_flat,
    input logic [NBANK*2*PINS-1:0]  cfg_flat,
    input logic                     irq
);

    logic stat_wr;
    assign stat_wr = reg_wr && (reg_addr >= AW'(STAT_BASE)) &&
                     (reg_addr < AW'(STAT_BASE + NBANK));

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stat_flat == '0 && cfg_flat == '0 && !irq));

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(cfg_flat));

    a_r6_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((~stat_flat & $past(stat_flat)) == '0));

    a_r7_baseline_quiet: assert property (@(posedge clk) disable iff (rst)
        (scan_done && scan_en && !base_valid) |=> ((stat_flat & ~$past(stat_flat)) == '0));

    a_r8_set_needs_scan: assert property (@(posedge clk) disable iff (rst)
        !scan_done |=> ((stat_flat & ~$past(stat_flat)) == '0));

    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> ((stat_flat & ~$past(stat_flat)) == '0));

    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        (hit_flat != '0) |=> ((stat_flat & $past(hit_flat)) == $past(hit_flat)));

    a_r10_no_status_no_irq: assert property (@(posedge clk) disable iff (rst)
        (stat_flat == '0) |-> !irq);

endmodule

bind sgp_event_det sgp_event_det_chk #(
    .NBANK (NBANK),
    .PINS  (PINS),
    .AW    (AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scan_en    (scan_en),
    .scan_done  (scan_done),
    .base_valid (base_valid),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .stat_flat  (stat_flat),
    .hit_flat   (hit_flat),
    .cfg_flat   (cfg_flat),
    .irq        (irq)
);

// File: tb/sgp_event_det_bench.sv
module sgp_event_det_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_en = 1'b1;
    logic        scan_done = 1'b0;
    logic [63:0] scan_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_size = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sgp_event_det u_sgp_event_det (
        .clk       (clk),
        .rst       (rst),
        .scan_en   (scan_en),
        .scan_done (scan_done),
        .scan_data (scan_data),
        .reg_wr    (reg_wr),
        .reg_size  (reg_size),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic half);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_size = half;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic half, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_size = half;
        #1 d = reg_rdata;
    endtask

    task automatic scan(input logic [63:0] v);
        @(negedge clk);
        scan_data = v; scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic clear_all();
        for (int b = 0; b < 8; b++) wr(6'h20 + 6'(b), 16'h00FF, 1'b0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        logic [63:0] ones;
        ones = '1;
        do_reset();

        // R1: reset state
        for (int b = 0; b < 8; b++) begin
            rd(6'h10 + 6'(2*b), 1'b1, d); chk("R1 cfg word", d, 0);
            rd(6'h20 + 6'(b), 1'b0, d);   chk("R1 status byte", d, 0);
        end
        chk("R1 irq", irq, 0);

        // R2: byte and halfword access to sensitivity words
        wr(6'h13, 16'h00A5, 1'b0);
        rd(6'h12, 1'b1, d); chk("R2 odd byte lane", d, 16'hA500);
        wr(6'h12, 16'h003C, 1'b0);
        rd(6'h12, 1'b1, d); chk("R2 even byte lane", d, 16'hA53C);
        rd(6'h13, 1'b0, d); chk("R2 odd byte read", d, 16'h00A5);
        rd(6'h12, 1'b0, d); chk("R2 even byte read", d, 16'h003C);
        wr(6'h1E, 16'h1234, 1'b1);
        rd(6'h1E, 1'b1, d); chk("R2 halfword", d, 16'h1234);
        wr(6'h12, 16'h0000, 1'b1);
        wr(6'h1E, 16'h0000, 1'b1);

        // R3 R4 R5: sweep every pin, mode and transition
        scan('0);
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 8; p++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int t = 0; t < 2; t++) begin
                        logic [63:0] v0, v1;
                        logic hit;
                        string tag;
                        v0 = 64'(t == 1) << (8*b + p);
                        v1 = 64'(t == 0) << (8*b + p);
                        hit = ((m & 1) != 0 && t == 0) || ((m & 2) != 0 && t == 1);
                        tag = (m == 1) ? "R3 rising" : (m == 2) ? "R4 falling" : "R5 both/off";
                        wr(6'h10 + 6'(2*b), 16'h0000, 1'b1);
                        scan(v0);
                        wr(6'h10 + 6'(2*b), 16'(m) << (2*p), 1'b1);
                        scan(v1);
                        rd(6'h20 + 6'(b), 1'b0, d);
                        chk(tag, d, 64'(hit) << p);
                        chk({tag, " irq"}, irq, hit);
                        wr(6'h20 + 6'(b), 16'h00FF, 1'b0);
                        wr(6'h10 + 6'(2*b), 16'h0000, 1'b1);
                    end
                end
            end
        end

        // R7: first scan after reset is a baseline
        do_reset();
        for (int b = 0; b < 8; b++) wr(6'h10 + 6'(2*b), 16'hFFFF, 1'b1);
        scan(ones);
        for (int b = 0; b < 8; b++) begin
            rd(6'h20 + 6'(b), 1'b0, d); chk("R7 baseline after reset", d, 0);
        end
        chk("R7 irq quiet", irq, 0);
        scan('0);
        for (int b = 0; b < 8; b++) begin
            rd(6'h20 + 6'(b), 1'b0, d); chk("R5 all pins falling", d, 16'h00FF);
        end
        chk("R10 irq raised", irq, 1);
        clear_all();
        chk("R6 all cleared irq", irq, 0);

        // R11: disabled detector ignores scans; R7 re-enable baseline
        @(negedge clk); scan_en = 1'b0;
        scan(ones);
        rd(6'h20, 1'b0, d); chk("R11 disabled scan", d, 0);
        @(negedge clk); scan_en = 1'b1;
        scan(ones);
        for (int b = 0; b < 8; b++) begin
            rd(6'h20 + 6'(b), 1'b0, d); chk("R7 baseline after enable", d, 0);
        end

        // R8: data changes without a pulse are ignored
        @(negedge clk); scan_data = '0;
        repeat (3) @(negedge clk);
        rd(6'h23, 1'b0, d); chk("R8 no pulse", d, 0);
        scan(ones);
        rd(6'h23, 1'b0, d); chk("R8 baseline kept", d, 0);

        // R9: event and clear in the same cycle
        for (int b = 1; b < 8; b++) wr(6'h10 + 6'(2*b), 16'h0000, 1'b1);
        wr(6'h10, 16'h000F, 1'b1);
        scan(ones & ~64'h3);
        rd(6'h20, 1'b0, d); chk("R4/R5 two pins set", d, 16'h0003);
        @(negedge clk);
        scan_data = ones & ~64'h2; scan_done = 1'b1;
        reg_wr = 1'b1; reg_addr = 6'h20; reg_wdata = 16'h0003; reg_size = 1'b0;
        @(negedge clk);
        scan_done = 1'b0; reg_wr = 1'b0;
        rd(6'h20, 1'b0, d); chk("R9 new event wins", d, 16'h0001);

        // R10: masking by sensitivity field
        chk("R10 irq armed", irq, 1);
        wr(6'h10, 16'h000C, 1'b0);
        chk("R10 irq masked", irq, 0);
        rd(6'h20, 1'b0, d); chk("R10 status kept", d, 16'h0001);
        wr(6'h10, 16'h000F, 1'b0);
        chk("R10 irq rearmed", irq, 1);

        // R6: zero writes no effect, one writes clear
        wr(6'h20, 16'h0000, 1'b0);
        rd(6'h20, 1'b0, d); chk("R6 zero write", d, 16'h0001);
        wr(6'h20, 16'h0001, 1'b0);
        rd(6'h20, 1'b0, d); chk("R6 one write", d, 0);
        chk("R6 irq after clear", irq, 0);

        done = 1;
        finish_run();
    end

endmodule